// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block is the configuration port of a frequency synthesizer. A host loads it through three wires: a serial clock, a serial data line and write strobes. Bits go in least significant first. They land in a 20-bit primary frequency word or in an 8-bit enhancement word, and an enhancement-write line picks which one. A rising edge on the secondary-write strobe copies the primary word into a 20-bit secondary word. That gives two stored frequency words, and the host can switch between them with a single select pin.

The selected 20-bit word is presented to the divider chain as three fields: a 6-bit reference-divider value, a 13-bit main-divider value and one control bit. The enhancement bits reach the rest of the chip only while the active-low enhancement enable is held low. A serial data-out line shows the bit that the next shift will push out of the primary word.

The port lives in the chip's system clock domain (`clk`). The serial clock and the strobes are sampled into that domain and acted upon at their rising edges. A serial or strobe edge is acted on two system clock cycles after the pin rises.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset the primary, secondary and enhancement words are all zero, so every output reads zero.
- R2: A serial clock rise with `eWr` low and `sWr` low shifts the primary word right by one bit, with `sData` entering bit 19. After 20 such shifts, the first bit sent sits in bit 0.
- R3: A serial clock rise with `eWr` high and `sWr` low shifts the enhancement word in the same way, with `sData` entering bit 7. The primary and secondary words keep their values.
- R4: A rise of `sWr` copies the primary word into the secondary word. No serial shift changes the secondary word.
- R5: `fSel` = 1 presents the primary word on the divider outputs, and `fSel` = 0 presents the secondary word.
- R6: The fields of the presented word are placed as follows: `refDivOut` carries bits 5..0, `mainDivOut` carries bits 18..6 and `ctlOut` carries bit 19.
- R7: While `enhN` is high, `enhOut` is all zero. While `enhN` is low, `enhOut` equals the enhancement word.
- R8: A serial clock rise that arrives while `sWr` is high shifts nothing. Both the primary and enhancement words keep their values.
- R9: `dataOut` equals bit 0 of the primary word. After each primary shift it therefore shows the next bit of the loaded word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sClk | input | 1 | Serial clock; data is taken on its rising edge |
| sData | input | 1 | Serial data, least significant bit first |
| sWr | input | 1 | Secondary-write strobe; its rise copies primary to secondary |
| eWr | input | 1 | Enhancement write enable; steers shifts into the enhancement word |
| fSel | input | 1 | Word select: 1 = primary, 0 = secondary |
| enhN | input | 1 | Active-low enable of the enhancement bits |
| refDivOut | output | 6 | Reference divider field of the selected word |
| mainDivOut | output | 13 | Main divider field of the selected word |
| ctlOut | output | 1 | Control bit of the selected word |
| enhOut | output | 8 | Enhancement bits, zero unless enabled |
| dataOut | output | 1 | Serial data out (primary bit 0) |

## Verification
The assertions assume the following about the inputs:
- Every level of `sClk` and `sWr` lasts at least two system clock cycles, so that each edge is seen exactly once.
- `sData` and `eWr` are steady for the two cycles around each serial clock rise.

The stimulus respects these assumptions. It holds data and the steering lines for three cycles before raising `sClk`, holds each serial clock phase for three cycles, and changes the strobes only while `sClk` is low.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;
  typedef struct packed {
    logic shiftPri;
    logic shiftEnh;
    logic copySec;
  } cfgStrobe_t;
endpackage

// File: rtl/cfg_serial_ctrl.sv
module cfg_serial_ctrl
  import cfg_serial_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sClk,
  input  logic       sData,
  input  logic       sWr,
  input  logic       eWr,
  output cfgStrobe_t strobe,
  output logic       dataBit
);
  logic [1:0] clkPipe;
  logic [1:0] wrPipe;
  logic       dataS;
  logic       eWrS;
  logic       clkRise;
  logic       wrRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPipe <= '0;
      wrPipe  <= '0;
      dataS   <= 1'b0;
      eWrS    <= 1'b0;
    end else begin
      clkPipe <= {clkPipe[0], sClk};
      wrPipe  <= {wrPipe[0], sWr};
      dataS   <= sData;
      eWrS    <= eWr;
    end
  end

  assign clkRise = clkPipe[0] & ~clkPipe[1];
  assign wrRise  = wrPipe[0] & ~wrPipe[1];

  always_comb begin
    strobe.shiftPri = clkRise & ~wrPipe[0] & ~eWrS;
    strobe.shiftEnh = clkRise & ~wrPipe[0] & eWrS;
    strobe.copySec  = wrRise;
  end

  assign dataBit = dataS;
endmodule

// File: rtl/cfg_serial_dpath.sv
module cfg_serial_dpath
  import cfg_serial_pkg::*;
#(
  parameter int WORD_W = 20,
  parameter int ENH_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strobe,
  input  logic              dataBit,
  input  logic              fSel,
  input  logic              enhN,
  output logic [WORD_W-1:0] priQ,
  output logic [WORD_W-1:0] secQ,
  output logic [WORD_W-1:0] selWord,
  output logic [ENH_W-1:0]  enhOut
);
  logic [ENH_W-1:0] enhQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      priQ <= '0;
      secQ <= '0;
      enhQ <= '0;
    end else begin
      if (strobe.shiftPri) priQ <= {dataBit, priQ[WORD_W-1:1]};
      if (strobe.shiftEnh) enhQ <= {dataBit, enhQ[ENH_W-1:1]};
      if (strobe.copySec)  secQ <= priQ;
    end
  end

  assign selWord = fSel ? priQ : secQ;

  for (genvar b = 0; b < ENH_W; b++) begin : g_enhGate
    assign enhOut[b] = enhQ[b] & ~enhN;
  end
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_serial_pkg::*;
#(
  parameter int WORD_W = 20,
  parameter int R_W    = 6,
  parameter int M_W    = 13,
  parameter int ENH_W  = 8,
  localparam int CTL_W = WORD_W - R_W - M_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sClk,
  input  logic             sData,
  input  logic             sWr,
  input  logic             eWr,
  input  logic             fSel,
  input  logic             enhN,
  output logic [R_W-1:0]   refDivOut,
  output logic [M_W-1:0]   mainDivOut,
  output logic [CTL_W-1:0] ctlOut,
  output logic [ENH_W-1:0] enhOut,
  output logic             dataOut
);
  cfgStrobe_t        strobe;
  logic              dataBit;
  logic [WORD_W-1:0] priQ;
  logic [WORD_W-1:0] secQ;
  logic [WORD_W-1:0] selWord;

  cfg_serial_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sClk(sClk), .sData(sData),
    .sWr(sWr), .eWr(eWr), .strobe(strobe), .dataBit(dataBit)
  );

  cfg_serial_dpath #(.WORD_W(WORD_W), .ENH_W(ENH_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataBit(dataBit),
    .fSel(fSel), .enhN(enhN), .priQ(priQ), .secQ(secQ),
    .selWord(selWord), .enhOut(enhOut)
  );

  assign refDivOut  = selWord[R_W-1:0];
  assign mainDivOut = selWord[R_W+M_W-1:R_W];
  assign ctlOut     = selWord[WORD_W-1:R_W+M_W];
  assign dataOut    = priQ[0];
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk
  import cfg_serial_pkg::*;
#(
  parameter int WORD_W = 20,
  parameter int R_W    = 6,
  parameter int ENH_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input cfgStrobe_t        strobe,
  input logic [WORD_W-1:0] priQ,
  input logic [WORD_W-1:0] secQ,
  input logic              fSel,
  input logic              enhN,
  input logic [R_W-1:0]    refDivOut,
  input logic [ENH_W-1:0]  enhOut,
  input logic              dataOut
);
  // R2
  pri_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftPri |=> priQ[WORD_W-2:0] == $past(priQ[WORD_W-1:1]));
  // R3
  enh_keeps_pri_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEnh |=> $stable(priQ) && $stable(secQ));
  // R4
  sec_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.copySec |=> secQ == $past(priQ));
  // R4
  sec_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.copySec |=> $stable(secQ));
  // R5
  sel_pri_chk: assert property (@(posedge clk) disable iff (!rstN)
    fSel |-> refDivOut == priQ[R_W-1:0]);
  // R7
  enh_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    enhN |-> enhOut == '0);
  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.shiftPri, strobe.shiftEnh, strobe.copySec}));
  // R9
  dout_next_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftPri |=> dataOut == $past(priQ[1]));
endmodule

bind cfg_serial_port cfg_serial_port_chk #(.WORD_W(WORD_W), .R_W(R_W), .ENH_W(ENH_W)) u_chk (
  .clk(clk), .rstN(rstN), .strobe(strobe), .priQ(priQ), .secQ(secQ),
  .fSel(fSel), .enhN(enhN), .refDivOut(refDivOut), .enhOut(enhOut),
  .dataOut(dataOut)
);

// File: tb/sim_cfg_serial_port.sv
`timescale 1ns/1ps
module sim_cfg_serial_port;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sClk = 1'b0, sData = 1'b0, sWr = 1'b0, eWr = 1'b0, fSel = 1'b0, enhN = 1'b1;
  logic [5:0]  refDivOut;
  logic [12:0] mainDivOut;
  logic [0:0]  ctlOut;
  logic [7:0]  enhOut;
  logic        dataOut;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cfg_serial_port u0 (
    .clk(clk), .rstN(rstN), .sClk(sClk), .sData(sData), .sWr(sWr), .eWr(eWr),
    .fSel(fSel), .enhN(enhN), .refDivOut(refDivOut), .mainDivOut(mainDivOut),
    .ctlOut(ctlOut), .enhOut(enhOut), .dataOut(dataOut)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    sData = b; waitN(3);
    sClk = 1'b1; waitN(3);
    sClk = 1'b0; waitN(3);
  endtask

  task automatic sendBits(input logic [31:0] v, input int n);
    for (int k = 0; k < n; k++) sendBit(v[k]);
  endtask

  task automatic pulseWr();
    sWr = 1'b1; waitN(3);
    sWr = 1'b0; waitN(3);
  endtask

  // expected fields computed arithmetically from the word (R6)
  task automatic chkWord(input string tag, input int w);
    chk({tag, " R6 ref"}, 32'(refDivOut), 32'(w % 64));
    chk({tag, " R6 main"}, 32'(mainDivOut), 32'((w / 64) % 8192));
    chk({tag, " R6 ctl"}, 32'(ctlOut), 32'(w / 524288));
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int prevSec;
    waitN(4);
    // R1 reset state
    fSel = 1'b1; enhN = 1'b0; waitN(1);
    chkWord("R1 pri", 0);
    chk("R1 enh", 32'(enhOut), 0);
    chk("R1 dout", 32'(dataOut), 0);
    rstN = 1'b1; waitN(3);
    fSel = 1'b0; waitN(1);
    chkWord("R1 sec", 0);
    prevSec = 0;

    for (int i = 0; i < 40; i++) begin
      int w;
      int e;
      w = (i < 20) ? (1 << i) : ((i * 40503 + 12345) % 1048576);
      e = (i * 37 + 5) % 256;
      eWr = 1'b0;
      sendBits(32'(w), 20);
      fSel = 1'b1; waitN(1);
      chkWord("R2 R5 primary", w);
      chk("R9 dout first", 32'(dataOut), 32'(w % 2));
      fSel = 1'b0; waitN(1);
      chkWord("R4 R5 secondary before copy", prevSec);
      pulseWr();
      chkWord("R4 secondary after copy", w);
      prevSec = w;
      // enhancement load must leave primary untouched
      eWr = 1'b1; waitN(2);
      sendBits(32'(e), 8);
      eWr = 1'b0; waitN(2);
      fSel = 1'b1; waitN(1);
      chkWord("R3 primary kept", w);
      enhN = 1'b0; waitN(1);
      chk("R3 R7 enh enabled", 32'(enhOut), 32'(e));
      enhN = 1'b1; waitN(1);
      chk("R7 enh gated", 32'(enhOut), 0);
      // serial clock while sWr high is ignored
      sWr = 1'b1; waitN(3);
      sendBit(~w[0]);
      eWr = 1'b1; waitN(2);
      sendBit(~e[7]);
      eWr = 1'b0; waitN(2);
      sWr = 1'b0; waitN(3);
      chkWord("R8 primary kept", w);
      enhN = 1'b0; waitN(1);
      chk("R8 enh kept", 32'(enhOut), 32'(e));
      enhN = 1'b1;
      // one more shift exposes next bit
      sendBit(1'b1);
      chk("R9 dout next", 32'(dataOut), 32'((w / 2) % 2));
      fSel = 1'b0; waitN(1);
      chkWord("R4 secondary after shift", w);
    end

    // exhaustive enhancement sweep
    enhN = 1'b0;
    for (int v = 0; v < 256; v++) begin
      eWr = 1'b1; waitN(2);
      sendBits(32'(v), 8);
      eWr = 1'b0; waitN(2);
      chk("R3 R7 enh sweep", 32'(enhOut), 32'(v));
    end
    fSel = 1'b0; waitN(1);
    chkWord("R3 secondary after sweep", prevSec);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule